// File: doc/BRIEF.md
# ECC-Protected Line Store with Deferred Poison Reporting

This block is a small direct-mapped data store for a cache. Every line holds one data word, the SECDED check bits for that word, and a one-bit poison flag. A write or fill encodes the incoming word and stores it with fresh check bits. A read decodes the stored codeword. A single flipped bit is repaired, both in the returned data and in the array. A double flip is not repaired. Instead of faulting at once, the block marks that line poisoned. It reports an error only to a requester that reads that exact line.

A background scrubber walks the lines in the cycles when the request port is idle. It finds latent errors before any requester consumes them. It repairs single flips in place and poisons lines it cannot repair. Two saturating counters record how many errors were corrected and how many were uncorrectable. For testing, two injection inputs can flip chosen codeword positions as a word is written.

The scrubber is a three-state machine. The states are as follows.

- `ST_OFF`: the scrubber is disabled.
- `ST_WAIT`: the scrubber counts down a gap of SCRUB_GAP+1 cycles.
- `ST_SCAN`: the scrubber waits for an idle cycle and then checks one line.

The transitions are as follows.

- OFF goes to WAIT when the enable rises.
- WAIT goes to SCAN when the gap expires.
- SCAN goes to WAIT after a line has been checked, which happens in a cycle with no request.
- WAIT and SCAN go to OFF when the enable drops.

Top module: `ecc_poison_store`

## Requirements
- R1: Codeword layout. The stored codeword has DATA_W+P+1 bits, which is 72 bits by default.
  - Position 0 holds even parity over the whole codeword.
  - Positions 1 to DATA_W+P form a Hamming code. The parity bits sit at the power-of-two positions. The data bits fill the other positions in ascending order, starting with data bit 0.
- R2: A write (req_write=1) encodes req_wdata and stores it at req_addr, and it clears that line's poison flag. Each injection input that is enabled flips its chosen codeword position (0 to 71) in the stored word. A write produces no response.
- R3: A read (req_valid=1, req_write=0) is answered on the next clock edge. That edge raises rsp_valid for one cycle and presents rsp_rdata, rsp_err and rsp_fixed. A read of a line that is clean and has no error returns the written data with rsp_err=0 and rsp_fixed=0.
- R4: When a read finds a single flipped bit, at any position including 0, the block does all of the following:
  - It returns the corrected data with rsp_fixed=1 and rsp_err=0.
  - It writes the repaired codeword back, so a later read returns rsp_fixed=0.
  - It does not set poison.
- R5: When a read finds a double flip, it returns rsp_err=1 and rsp_rdata=0, and it sets that line's poison flag.
- R6: Every later read of a poisoned line returns rsp_err=1 and rsp_rdata=0, and no error counter changes. Reads of other lines are unaffected.
- R7: ce_count and ue_count start at zero. Each counts one per newly detected correctable or uncorrectable error, from reads or from the scrubber. Each stops at 2^CNT_W-1.
- R8: When scrub_en=1, the scrubber follows the OFF/WAIT/SCAN states. It checks one line per slot, and only in a cycle with req_valid=0. It walks the addresses upward and wraps after the last line.
- R9: A scrub check does the following:
  - It writes back a repaired single-bit error and counts it in ce_count.
  - It poisons a line with a double error and counts it in ue_count.
  - It skips a line that is already poisoned.
- R10: After reset, the block is in the following state:
  - Every line holds data 0, clean and unpoisoned.
  - Both counters are 0.
  - rsp_valid is 0.
  - The scrubber is in OFF with its pointer at line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write or fill, 0 = read |
| req_addr | input | ADDR_W | Line index |
| req_wdata | input | DATA_W | Write data |
| inj_a_en | input | 1 | Flip codeword position inj_a_pos on this write |
| inj_a_pos | input | POS_W | First injection position |
| inj_b_en | input | 1 | Flip codeword position inj_b_pos on this write |
| inj_b_pos | input | POS_W | Second injection position |
| scrub_en | input | 1 | Enable the background scrubber |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | DATA_W | Read data, corrected, or 0 on error |
| rsp_err | output | 1 | The line read is poisoned |
| rsp_fixed | output | 1 | A single-bit error was corrected |
| ce_count | output | CNT_W | Saturating count of corrected errors |
| ue_count | output | CNT_W | Saturating count of uncorrectable errors |

## Verification
The assertions check the following on every cycle:

- A read of a poisoned line always yields an error response with zeroed data.
- A write always leaves its line unpoisoned.
- A response never reports an error and a correction together, and it only ever follows a read.
- The counters never fall and hold at their ceiling.
- The scrub pointer never moves while a request occupies the port, and it stays inside the array.

Only the bench scenarios can show the following:

- The actual error classification for chosen flip positions, including the overall-parity bit.
- That a repair was really written back.
- That poison stays sticky until a rewrite.
- That an idle scrubber pass finds and handles latent errors, as seen through later reads and the counters.

// File: rtl/ecc_store_pkg.sv
package ecc_store_pkg;

    // Smallest Hamming parity count p with 2**p >= data + p + 1.
    function automatic int hamming_bits(input int data_w);
        int p;
        p = 1;
        while ((1 << p) < data_w + p + 1) p++;
        return p;
    endfunction

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SCAN = 2'd2
    } scrub_state_e;

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
    parameter int DATA_W = 64,
    localparam int CHK_W = ecc_store_pkg::hamming_bits(DATA_W),
    localparam int HAM_N = DATA_W + CHK_W,
    localparam int CW_W  = HAM_N + 1
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CW_W-1:0]   cw_out
);

    always_comb begin : build
        logic [CW_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        // Scatter data over non-power-of-two Hamming positions.
        for (int j = 1; j <= HAM_N; j++) begin
            if ((j & (j - 1)) != 0) begin
                c[j] = data_in[k];
                k++;
            end
        end
        // Each parity bit covers the positions whose index has its bit set.
        for (int i = 0; i < CHK_W; i++) begin
            logic b;
            b = 1'b0;
            for (int j = 1; j <= HAM_N; j++) begin
                if ((j & (1 << i)) != 0) b = b ^ c[j];
            end
            c[1 << i] = b;
        end
        c[0] = ^c[HAM_N:1];
        cw_out = c;
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
    parameter int DATA_W = 64,
    localparam int CHK_W = ecc_store_pkg::hamming_bits(DATA_W),
    localparam int HAM_N = DATA_W + CHK_W,
    localparam int CW_W  = HAM_N + 1
) (
    input  logic [CW_W-1:0]   cw_in,
    output logic [CW_W-1:0]   cw_fixed,
    output logic [DATA_W-1:0] data_out,
    output logic              err_single,
    output logic              err_double
);

    logic [CHK_W-1:0] syndrome;
    logic             parity_odd;

    always_comb begin
        syndrome = '0;
        for (int j = 1; j <= HAM_N; j++) begin
            if (cw_in[j]) syndrome = syndrome ^ CHK_W'(j);
        end
        parity_odd = ^cw_in;
    end

    always_comb begin
        cw_fixed   = cw_in;
        err_single = 1'b0;
        err_double = 1'b0;
        if (parity_odd) begin
            if (int'(syndrome) <= HAM_N) begin
                err_single = 1'b1;
                for (int j = 0; j <= HAM_N; j++) begin
                    if (syndrome == CHK_W'(j)) cw_fixed[j] = ~cw_in[j];
                end
            end else begin
                err_double = 1'b1;
            end
        end else if (syndrome != '0) begin
            err_double = 1'b1;
        end
    end

    always_comb begin : gather
        int k;
        k = 0;
        data_out = '0;
        for (int j = 1; j <= HAM_N; j++) begin
            if ((j & (j - 1)) != 0) begin
                data_out[k] = cw_fixed[j];
                k++;
            end
        end
    end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 8,
    localparam logic [W-1:0] TOP = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && count != TOP) begin
            count <= count + 1'b1;
        end
    end

    assert_ceiling_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count == TOP |=> count == TOP);

    assert_never_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count >= $past(count));

endmodule

// File: rtl/scrub_fsm.sv
module scrub_fsm
    import ecc_store_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int SCRUB_GAP = 64,
    localparam int ADDR_W = $clog2(NUM_LINES),
    localparam int GAP_W  = $clog2(SCRUB_GAP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              port_busy,
    output logic              go,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] LAST_LINE = ADDR_W'(NUM_LINES - 1);

    scrub_state_e     state_q, state_d;
    logic [GAP_W-1:0] gap_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (enable) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!enable)           state_d = ST_OFF;
                else if (gap_q == '0)  state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (!enable)           state_d = ST_OFF;
                else if (!port_busy)   state_d = ST_WAIT;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs.
    always_comb begin
        go = (state_q == ST_SCAN) && enable && !port_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(SCRUB_GAP);
            ptr   <= '0;
        end else begin
            if (state_q != ST_WAIT)  gap_q <= GAP_W'(SCRUB_GAP);
            else if (gap_q != '0)    gap_q <= gap_q - 1'b1;
            if (go) ptr <= (ptr == LAST_LINE) ? '0 : ptr + 1'b1;
        end
    end

    assert_idle_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        port_busy |=> $stable(ptr));

    assert_ptr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST_LINE);

endmodule

// File: rtl/ecc_poison_store.sv
module ecc_poison_store #(
    parameter int DATA_W    = 64,
    parameter int NUM_LINES = 16,
    parameter int CNT_W     = 8,
    parameter int SCRUB_GAP = 64,
    localparam int ADDR_W = $clog2(NUM_LINES),
    localparam int CHK_W  = ecc_store_pkg::hamming_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W + 1,
    localparam int POS_W  = $clog2(CW_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              inj_a_en,
    input  logic [POS_W-1:0]  inj_a_pos,
    input  logic              inj_b_en,
    input  logic [POS_W-1:0]  inj_b_pos,
    input  logic              scrub_en,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              rsp_fixed,
    output logic [CNT_W-1:0]  ce_count,
    output logic [CNT_W-1:0]  ue_count
);

    logic [CW_W-1:0]   line_cw [NUM_LINES];
    logic              poison_q [NUM_LINES];

    logic [CW_W-1:0]   enc_cw, inj_mask, cur_cw, dec_cw;
    logic [DATA_W-1:0] dec_data;
    logic              dec_single, dec_double;
    logic [ADDR_W-1:0] scrub_ptr, look_addr;
    logic              scrub_go, rd_req, wr_req, cur_poison, check_now;
    logic              ce_hit, ue_hit;

    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data_in (req_wdata),
        .cw_out  (enc_cw)
    );

    secded_dec #(.DATA_W(DATA_W)) u_dec (
        .cw_in      (cur_cw),
        .cw_fixed   (dec_cw),
        .data_out   (dec_data),
        .err_single (dec_single),
        .err_double (dec_double)
    );

    scrub_fsm #(.NUM_LINES(NUM_LINES), .SCRUB_GAP(SCRUB_GAP)) u_scrub (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (scrub_en),
        .port_busy (req_valid),
        .go        (scrub_go),
        .ptr       (scrub_ptr)
    );

    // Injection mask: each enabled input flips one codeword position.
    always_comb begin
        inj_mask = '0;
        for (int j = 0; j < CW_W; j++) begin
            if (inj_a_en && inj_a_pos == POS_W'(j)) inj_mask[j] = ~inj_mask[j];
            if (inj_b_en && inj_b_pos == POS_W'(j)) inj_mask[j] = ~inj_mask[j];
        end
    end

    always_comb begin
        wr_req     = req_valid && req_write;
        rd_req     = req_valid && !req_write;
        look_addr  = req_valid ? req_addr : scrub_ptr;
        cur_cw     = line_cw[look_addr];
        cur_poison = poison_q[look_addr];
        check_now  = (rd_req || scrub_go) && !cur_poison;
        ce_hit     = check_now && dec_single;
        ue_hit     = check_now && dec_double;
    end

    // Array and poison flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                line_cw[i]  <= '0;
                poison_q[i] <= 1'b0;
            end
        end else if (wr_req) begin
            line_cw[req_addr]  <= enc_cw ^ inj_mask;
            poison_q[req_addr] <= 1'b0;
        end else if (ce_hit) begin
            line_cw[look_addr] <= dec_cw;
        end else if (ue_hit) begin
            poison_q[look_addr] <= 1'b1;
        end
    end

    // Read response, one edge after the request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            rsp_fixed <= 1'b0;
        end else begin
            rsp_valid <= rd_req;
            rsp_err   <= rd_req && (cur_poison || dec_double);
            rsp_fixed <= rd_req && !cur_poison && dec_single;
            rsp_rdata <= (rd_req && !cur_poison && !dec_double) ? dec_data : '0;
        end
    end

    sat_counter #(.W(CNT_W)) u_ce_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (ce_hit),
        .count (ce_count)
    );

    sat_counter #(.W(CNT_W)) u_ue_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (ue_hit),
        .count (ue_count)
    );

    assert_poison_read_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && poison_q[req_addr] |=> rsp_valid && rsp_err && rsp_rdata == '0);

    assert_write_clears_poison_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !poison_q[$past(req_addr)]);

    assert_rsp_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    assert_err_fix_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_err && rsp_fixed));

    assert_double_poisons_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ue_hit |=> poison_q[$past(look_addr)]);

endmodule

// File: tb/sim_ecc_poison_store.sv
module sim_ecc_poison_store;

    localparam int DW   = 64;
    localparam int AW   = 4;
    localparam int PW   = 7;
    localparam int CW   = 4;
    localparam int CMAX = 15;
    localparam int VW   = 86;
    localparam int NV   = 8;

    // {addr, data, inj_a_en, inj_a_pos, inj_b_en, inj_b_pos, exp_err, exp_fixed}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd0,  64'h0123_4567_89AB_CDEF, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b0},
        {4'd1,  64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 7'd5,  1'b0, 7'd0,  1'b0, 1'b1},
        {4'd2,  64'h0000_0000_0000_0000, 1'b1, 7'd0,  1'b0, 7'd0,  1'b0, 1'b1},
        {4'd3,  64'hA5A5_A5A5_A5A5_A5A5, 1'b0, 7'd0,  1'b1, 7'd71, 1'b0, 1'b1},
        {4'd4,  64'h5A5A_0F0F_F0F0_1234, 1'b1, 7'd3,  1'b1, 7'd40, 1'b1, 1'b0},
        {4'd5,  64'hDEAD_BEEF_CAFE_F00D, 1'b1, 7'd0,  1'b1, 7'd64, 1'b1, 1'b0},
        {4'd6,  64'h0000_0000_0000_0001, 1'b1, 7'd1,  1'b0, 7'd0,  1'b0, 1'b1},
        {4'd15, 64'hCAFE_0000_1111_BEEF, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          inj_a_en = 1'b0, inj_b_en = 1'b0;
    logic [PW-1:0] inj_a_pos = '0, inj_b_pos = '0;
    logic          scrub_en = 1'b0;
    logic          rsp_valid, rsp_err, rsp_fixed;
    logic [DW-1:0] rsp_rdata;
    logic [CW-1:0] ce_count, ue_count;

    int n_cmp = 0;
    int n_bad = 0;
    int ce_exp = 0;
    int ue_exp = 0;

    always #10 clk = ~clk;

    ecc_poison_store #(.DATA_W(DW), .NUM_LINES(16), .CNT_W(CW), .SCRUB_GAP(4)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .inj_a_en(inj_a_en),
        .inj_a_pos(inj_a_pos), .inj_b_en(inj_b_en), .inj_b_pos(inj_b_pos),
        .scrub_en(scrub_en), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .rsp_fixed(rsp_fixed), .ce_count(ce_count),
        .ue_count(ue_count)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic ea, input logic [PW-1:0] pa,
                      input logic eb, input logic [PW-1:0] pb);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        inj_a_en = ea; inj_a_pos = pa; inj_b_en = eb; inj_b_pos = pb;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; inj_a_en = 1'b0; inj_b_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic int bump(input int v);
        return (v < CMAX) ? v + 1 : CMAX;
    endfunction

    task automatic check_read(input string tag, input logic [DW-1:0] d,
                              input logic e, input logic f);
        check({tag, " valid"}, DW'(rsp_valid), DW'(1));
        check({tag, " data"},  rsp_rdata, e ? '0 : d);
        check({tag, " err"},   DW'(rsp_err), DW'(e));
        check({tag, " fixed"}, DW'(rsp_fixed), DW'(f));
    endtask

    task automatic check_counts(input string tag);
        check({tag, " ce_count"}, DW'(ce_count), DW'(ce_exp));
        check({tag, " ue_count"}, DW'(ue_count), DW'(ue_exp));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 rsp_valid", DW'(rsp_valid), '0);
        check_counts("R10");
        rd(4'd12);
        check_read("R10 zeroed line", '0, 1'b0, 1'b0);

        // R1 R2 R3 R4 R5: vector walk, write with injection then read back
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            wr(v[85:82], v[81:18], v[17], v[16:10], v[9], v[8:2]);
            check("R3 no rsp on write", DW'(rsp_valid), '0);
            rd(v[85:82]);
            if (v[1]) ue_exp = bump(ue_exp);
            if (v[0]) ce_exp = bump(ce_exp);
            check_read($sformatf("R1 R4 R5 vec%0d", i), v[81:18], v[1], v[0]);
            check_counts($sformatf("R7 vec%0d", i));
        end

        // R4: repair was written back
        rd(4'd1);
        check_read("R4 writeback", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        check_counts("R4 no recount");

        // R6: poison sticky, neighbours unaffected
        rd(4'd4);
        check_read("R6 sticky", '0, 1'b1, 1'b0);
        rd(4'd0);
        check_read("R6 other line", 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0);
        rd(4'd5);
        check_read("R6 sticky b", '0, 1'b1, 1'b0);
        check_counts("R6 no recount");

        // R2: rewrite clears poison
        wr(4'd4, 64'h1357_9BDF_2468_ACE0, 1'b0, '0, 1'b0, '0);
        rd(4'd4);
        check_read("R2 clear poison", 64'h1357_9BDF_2468_ACE0, 1'b0, 1'b0);

        // R8 R9: latent errors found by the scrubber
        wr(4'd8, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, 7'd33, 1'b0, '0);
        wr(4'd9, 64'h7777_8888_9999_AAAA, 1'b1, 7'd10, 1'b1, 7'd50);
        check_counts("R8 before scrub");
        @(negedge clk);
        scrub_en = 1'b1;
        repeat (400) @(negedge clk);
        scrub_en = 1'b0;
        repeat (3) @(negedge clk);
        ce_exp = bump(ce_exp);
        ue_exp = bump(ue_exp);
        check_counts("R9 scrub counts");
        rd(4'd8);
        check_read("R9 scrub repaired", 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, 1'b0);
        rd(4'd9);
        check_read("R9 scrub poisoned", '0, 1'b1, 1'b0);
        rd(4'd5);
        check_read("R9 skip poisoned", '0, 1'b1, 1'b0);
        check_counts("R9 after reads");

        // R7: saturation of both counters
        for (int i = 0; i < 14; i++) begin
            wr(4'd10, 64'h0000_1111_2222_3333, 1'b1, 7'd7, 1'b0, '0);
            rd(4'd10);
            ce_exp = bump(ce_exp);
            wr(4'd11, 64'h4444_5555_6666_7777, 1'b1, 7'd2, 1'b1, 7'd20);
            rd(4'd11);
            check_read("R5 repeat double", '0, 1'b1, 1'b0);
            ue_exp = bump(ue_exp);
        end
        check("R7 ce saturated", DW'(ce_count), DW'(CMAX));
        check("R7 ue saturated", DW'(ue_count), DW'(CMAX));
        check_counts("R7 final");

        report();
    end

endmodule